// File: doc/BRIEF.md
# Framed Register-Write Command Decoder

This block sits behind a host serial receiver and converts a stream of bytes into register writes. It stays idle until it has seen a fixed five-byte start marker. It then reads the 16-bit command words that follow, until a one-byte terminator closes the frame. The most significant byte of each word arrives first.

Each word packs a 4-bit register address and an 8-bit value. The value is split across two separate bit fields, and the word also carries inverted copies of two value bits. The decoder checks this redundancy before it acts on a word. A correct word produces a single-cycle write strobe together with its address and value. A malformed word is discarded: the block raises a one-cycle error flag and goes back to searching for the start marker.

The inputs are a byte-valid signal and a byte value, so idle cycles between bytes are allowed. The block does not include the serial physical layer, the target registers or any read path.

Top module: `frame_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `wr_en` and `frame_error` are 0 and `wr_addr` and `wr_data` are zero. The decoder starts out searching for the start marker.
- R2: A frame opens only after the five bytes 0x40, 0x4C, 0x44, 0x53, 0x7E have been received in order. Bytes that do not complete this marker produce no output. A byte that breaks a partial match restarts the search, and it counts as the first marker byte if it equals 0x40.
- R3: A command word is two accepted bytes, high byte first. In the cycle after its low byte is accepted, a valid word drives `wr_en` high for exactly one cycle.
- R4: For a valid word w, `wr_addr` = w[11:8], `wr_data[5:0]` = w[5:0] and `wr_data[7:6]` = w[13:12].
- R5: A word is valid only when w[15] = 0, w[7] = 0, w[6] = ~w[5] and w[14] = ~w[13]. For an invalid word there is no `wr_en`; instead `frame_error` pulses for one cycle in the same cycle a write would have appeared. `wr_addr` and `wr_data` stay unchanged, and every later byte is ignored until a new start marker.
- R6: A 0x7E byte received where a new word's high byte is expected closes the frame. Bytes after it produce no writes until a new start marker is received.
- R7: A frame may carry any number of words. Each produces its own write, in the order the words were sent.
- R8: Cycles with `in_valid` low have no effect, so any number of idle cycles may separate bytes.
- R9: `wr_addr` and `wr_data` keep the values of the last write until the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_byte` holds a received byte this cycle |
| in_byte | input | 8 | Received byte |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 4 | Register address of the last write |
| wr_data | output | 8 | Value of the last write |
| frame_error | output | 1 | One-cycle pulse when a malformed word is dropped |

## Verification
Only one register stage separates the input from the outputs. `wr_en` or `frame_error` for a word is due in the cycle after the clock edge that accepts its low byte. Every other accepted byte, and every idle cycle, must leave both flags low.

The bench drives each byte at a falling edge and samples all four outputs one time unit after the following rising edge. It compares them against the expectation for that specific byte, so a write arriving one cycle early or late is caught on the byte it belongs to. The bench keeps its own copy of the last written address and value, which lets the hold behaviour be checked after every byte and every idle cycle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int SYNC_LEN = 5;

    localparam logic [BYTE_W-1:0] TERM_BYTE = 8'h7E;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_BOUND = 2'd1,
        ST_LOW   = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic              ok;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic [BYTE_W-1:0] sync_byte(input int unsigned idx);
        case (idx)
            0:       sync_byte = 8'h40;
            1:       sync_byte = 8'h4C;
            2:       sync_byte = 8'h44;
            3:       sync_byte = 8'h53;
            4:       sync_byte = 8'h7E;
            default: sync_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/fcd_word_check.sv
module fcd_word_check
    import fcd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd
);
    localparam int LO_VAL_W = 6;
    localparam int HI_VAL_W = DATA_W - LO_VAL_W;
    localparam int ADDR_LSB = 8;
    localparam int HI_LSB   = ADDR_LSB + ADDR_W;
    localparam int INV5_POS = LO_VAL_W;
    localparam int RSV_LO   = LO_VAL_W + 1;
    localparam int INV7_POS = HI_LSB + HI_VAL_W;
    localparam int RSV_HI   = WORD_W - 1;

    logic lo_pair_ok;
    logic hi_pair_ok;
    logic rsv_ok;

    always_comb begin
        lo_pair_ok = word[INV5_POS] != word[LO_VAL_W-1];
        hi_pair_ok = word[INV7_POS] != word[HI_LSB+HI_VAL_W-1];
        rsv_ok     = !word[RSV_HI] && !word[RSV_LO];

        cmd.ok   = lo_pair_ok && hi_pair_ok && rsv_ok;
        cmd.addr = word[ADDR_LSB +: ADDR_W];
        cmd.data = {word[HI_LSB +: HI_VAL_W], word[0 +: LO_VAL_W]};
    end

endmodule

// File: rtl/fcd_framer.sv
module fcd_framer
    import fcd_pkg::*;
#(
    parameter int N_SYNC = SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              word_ok,
    output logic              word_stb,
    output logic [WORD_W-1:0] word
);
    localparam int IDX_W = (N_SYNC > 1) ? $clog2(N_SYNC) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_SYNC - 1);

    typedef struct packed {
        fr_state_e         state;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] hi;
    } fr_regs_t;

    fr_regs_t fr_d, fr_q;

    always_comb begin
        fr_d     = fr_q;
        word_stb = 1'b0;
        word     = {fr_q.hi, in_byte};

        if (in_valid) begin
            case (fr_q.state)
                ST_HUNT: begin
                    if (in_byte == sync_byte(int'(fr_q.idx))) begin
                        if (fr_q.idx == IDX_LAST) begin
                            fr_d.state = ST_BOUND;
                            fr_d.idx   = '0;
                        end else begin
                            fr_d.idx = fr_q.idx + IDX_W'(1);
                        end
                    end else if (in_byte == sync_byte(0)) begin
                        fr_d.idx = IDX_W'(1);
                    end else begin
                        fr_d.idx = '0;
                    end
                end
                ST_BOUND: begin
                    if (in_byte == TERM_BYTE) begin
                        fr_d.state = ST_HUNT;
                        fr_d.idx   = '0;
                    end else begin
                        fr_d.hi    = in_byte;
                        fr_d.state = ST_LOW;
                    end
                end
                ST_LOW: begin
                    word_stb   = 1'b1;
                    fr_d.idx   = '0;
                    fr_d.state = word_ok ? ST_BOUND : ST_HUNT;
                end
                default: begin
                    fr_d.state = ST_HUNT;
                    fr_d.idx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q <= '{state: ST_HUNT, idx: '0, hi: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    // R6: terminator at a word boundary closes the frame
    assert_term_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.state == ST_BOUND && in_valid && in_byte == TERM_BYTE)
        |=> (fr_q.state == ST_HUNT && fr_q.idx == '0));

    // R5: a rejected word sends the decoder back to the marker search
    assert_bad_word_hunt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !word_ok) |=> (fr_q.state == ST_HUNT && fr_q.idx == '0));

    // R8: idle cycles leave the framing state untouched
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(fr_q));

    // R2: a frame opens only from the last marker position
    assert_open_from_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.state == ST_HUNT && fr_d.state == ST_BOUND)
        |-> (fr_q.idx == IDX_LAST && in_valid));

    always_comb begin
        if (rst_n) begin
            assert_idx_range_R2: assert (int'(fr_q.idx) < N_SYNC);
        end
    end

endmodule

// File: rtl/fcd_wr_stage.sv
module fcd_wr_stage
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  cmd_t              cmd,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_error
);
    typedef struct packed {
        logic              wr;
        logic              err;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_regs_t;

    wr_regs_t wr_d, wr_q;

    always_comb begin
        wr_d     = wr_q;
        wr_d.wr  = word_stb && cmd.ok;
        wr_d.err = word_stb && !cmd.ok;
        if (word_stb && cmd.ok) begin
            wr_d.addr = cmd.addr;
            wr_d.data = cmd.data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign wr_en       = wr_q.wr;
    assign frame_error = wr_q.err;
    assign wr_addr     = wr_q.addr;
    assign wr_data     = wr_q.data;

    // R3: a write strobe never lasts two cycles
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: a dropped word leaves the write outputs untouched
    assert_err_keeps_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> ($stable(wr_addr) && $stable(wr_data) && !wr_en));

    // R9: address and value only move together with a write strobe
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ($stable(wr_addr) && $stable(wr_data)));

endmodule

// File: rtl/frame_cmd_decoder.sv
module frame_cmd_decoder
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       wr_en,
    output logic [3:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       frame_error
);
    logic              word_stb;
    logic [WORD_W-1:0] word;
    cmd_t              cmd;

    fcd_framer #(
        .N_SYNC (SYNC_LEN)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .word_ok  (cmd.ok),
        .word_stb (word_stb),
        .word     (word)
    );

    fcd_word_check u_check (
        .word (word),
        .cmd  (cmd)
    );

    fcd_wr_stage u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_stb    (word_stb),
        .cmd         (cmd),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_error (frame_error)
    );

    // R3: every accepted valid word yields a strobe on the next cycle
    assert_word_to_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && cmd.ok) |=> (wr_en && wr_addr == $past(cmd.addr)
                                 && wr_data == $past(cmd.data)));

    // R5: every rejected word yields an error pulse on the next cycle
    assert_word_to_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !cmd.ok) |=> frame_error);

    // R1: no activity in the first cycle out of reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!wr_en && !frame_error));

endmodule

// File: tb/frame_cmd_decoder_test.sv
module frame_cmd_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       frame_error;

    int n_checks = 0;
    int n_errs   = 0;
    logic [3:0] last_a = 4'h0;
    logic [7:0] last_d = 8'h00;

    always #5 clk = ~clk;

    frame_cmd_decoder uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_error (frame_error)
    );

    // Encoding from R4/R5: {0, ~v7, v7, v6, addr, 0, ~v5, v5..v0}
    function automatic logic [15:0] enc(input logic [3:0] a, input logic [7:0] v);
        return {1'b0, ~v[7], v[7:6], a, 1'b0, ~v[5], v[5:0]};
    endfunction

    function automatic logic word_valid(input logic [15:0] w);
        return !w[15] && !w[7] && (w[6] != w[5]) && (w[14] != w[13]);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic look(input string req, input logic ew, input logic ee,
                        input logic [3:0] ea, input logic [7:0] ed);
        check({req, " wr_en"}, 32'(wr_en), 32'(ew));
        check({req, " frame_error"}, 32'(frame_error), 32'(ee));
        if (ew) begin
            last_a = ea;
            last_d = ed;
        end
        check({req, " wr_addr"}, 32'(wr_addr), 32'(last_a));
        check({req, " wr_data"}, 32'(wr_data), 32'(last_d));
    endtask

    task automatic put(input logic [7:0] b, input string req, input logic ew,
                       input logic ee, input logic [3:0] ea, input logic [7:0] ed);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        look(req, ew, ee, ea, ed);
    endtask

    task automatic quiet(input logic [7:0] b, input string req);
        put(b, req, 1'b0, 1'b0, 4'h0, 8'h00);
    endtask

    // R8: idle cycles with garbage on in_byte must change nothing
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'($urandom);
            @(posedge clk);
            #1;
            look("R8 idle", 1'b0, 1'b0, 4'h0, 8'h00);
        end
    endtask

    task automatic header();
        for (int i = 0; i < 5; i++) begin
            case (i)
                0: quiet(8'h40, "R2 marker");
                1: quiet(8'h4C, "R2 marker");
                2: quiet(8'h44, "R2 marker");
                3: quiet(8'h53, "R2 marker");
                default: quiet(8'h7E, "R2 marker");
            endcase
        end
    endtask

    // Sends one word; live says whether the frame is still being decoded.
    task automatic send_word(input logic [15:0] w, inout logic live, input int gaps);
        logic ok;
        ok = word_valid(w);
        quiet(w[15:8], "R3 high byte");
        idle(gaps);
        if (live && ok)
            put(w[7:0], "R4 R7 write", 1'b1, 1'b0, w[11:8], {w[13:12], w[5:0]});
        else if (live)
            put(w[7:0], "R5 reject", 1'b0, 1'b1, 4'h0, 8'h00);
        else
            quiet(w[7:0], "R5 R6 ignored");
        live = live && ok;
    endtask

    initial begin
        logic live;
        void'($urandom(32'd1234));

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        look("R1 in reset", 1'b0, 1'b0, 4'h0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        look("R1 after reset", 1'b0, 1'b0, 4'h0, 8'h00);

        // R3 R4: one word in one frame
        header();
        live = 1'b1;
        send_word(enc(4'h5, 8'hA7), live, 0);
        quiet(8'h7E, "R6 terminator");

        // R2: word bytes without a marker do nothing
        quiet(enc(4'h2, 8'h11)[15:8], "R2 no marker");
        quiet(enc(4'h2, 8'h11)[7:0], "R2 no marker");

        // R2: marker missing its first byte does nothing
        quiet(8'h4C, "R2 short marker"); quiet(8'h44, "R2 short marker");
        quiet(8'h53, "R2 short marker"); quiet(8'h7E, "R2 short marker");
        quiet(enc(4'h3, 8'h22)[15:8], "R2 short marker");
        quiet(enc(4'h3, 8'h22)[7:0], "R2 short marker");

        // R2: partial marker broken by 0x40 restarts the match
        quiet(8'h40, "R2 partial"); quiet(8'h4C, "R2 partial"); quiet(8'h44, "R2 partial");
        header();
        live = 1'b1;
        send_word(enc(4'hF, 8'hFF), live, 0);
        send_word(enc(4'h0, 8'h00), live, 0);
        // R7: several words in order, with gaps (R8)
        send_word(enc(4'h9, 8'h3C), live, 2);
        send_word(enc(4'h6, 8'hC3), live, 1);
        quiet(8'h7E, "R6 terminator");
        // R6: bytes after terminator ignored
        quiet(enc(4'h1, 8'h55)[15:8], "R6 after end");
        quiet(enc(4'h1, 8'h55)[7:0], "R6 after end");

        // R6: empty frame, then a normal one
        header();
        quiet(8'h7E, "R6 empty frame");
        header();
        live = 1'b1;
        send_word(enc(4'hA, 8'h81), live, 0);
        // R5: bad inverted copy of bit 7 (bit 14), later words dropped
        send_word(enc(4'h4, 8'h40) ^ 16'h4000, live, 0);
        send_word(enc(4'h7, 8'h77), live, 0);
        quiet(8'h7E, "R5 terminator after reject");
        // R5: bad bit 6 and bad bit 15
        header();
        live = 1'b1;
        send_word(enc(4'h8, 8'h21) ^ 16'h0040, live, 0);
        quiet(8'h7E, "R5 terminator");
        header();
        live = 1'b1;
        send_word(enc(4'h8, 8'h21) ^ 16'h8000, live, 0);
        quiet(8'h7E, "R5 terminator");

        // Random frames
        for (int f = 0; f < 80; f++) begin
            int nw;
            int noise;
            noise = int'($urandom % 4);
            for (int k = 0; k < noise; k++) begin
                logic [7:0] nb;
                nb = 8'($urandom);
                if (nb == 8'h7E) nb = 8'h00;
                quiet(nb, "R2 noise");
            end
            header();
            live = 1'b1;
            nw = int'($urandom % 7);
            for (int k = 0; k < nw; k++) begin
                logic [15:0] w;
                w = enc(4'($urandom), 8'($urandom));
                case ($urandom % 16)
                    0: w = w ^ 16'h8000;
                    1: w = w ^ 16'h0040;
                    2: w = w ^ 16'h0080;
                    default: ;
                endcase
                send_word(w, live, int'($urandom % 3));
                idle(int'($urandom % 2));
            end
            quiet(8'h7E, "R6 terminator");
        end

        idle(3);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule